// File: doc/BRIEF.md
# Dual-Processor Port Bridge with Cross-Coupled Control Nibbles

This block links a host processor bus to a disk-subsystem processor. Each side has its own small register window, addressed by a 2-bit offset and driven by one-cycle read and write strobes with 8-bit data. Two one-byte mailboxes carry bytes in each direction. The host writes a byte that the subsystem reads as incoming data. The subsystem writes a byte that the host reads back as a status or return byte.

Alongside the byte path, each side owns an 8-bit control latch. The peer sees only the upper half of that latch, and sees it in its own lower four bits. This gives each processor a 4-bit handshake channel, so strobes such as "data valid" or "accepted" can travel without extra wiring. Read data is registered: it appears on the cycle after the read strobe and holds until the next read strobe on that side.

Top module: `xbr_port_bridge`

## Requirements
- R1: After reset, both mailboxes, both control latches and both read-data outputs are 0x00.
- R2: A host write at offset 0 loads the host-to-subsystem mailbox. A later subsystem read at its offset 0 returns that byte.
- R3: A host write at offset 2 stores the full byte in the host control latch. A subsystem read at its offset 2 returns host-control bits 7:4 in bits 3:0, with bits 7:4 zero, so the low half of the host latch never reaches the subsystem.
- R4: A subsystem write at its offset 2 stores the byte in the subsystem control latch. A host read at offset 2 returns subsystem-control bits 7:4 in bits 3:0, with bits 7:4 zero.
- R5: A subsystem write at its offset 1 loads the subsystem-to-host mailbox. A host read at offset 1 returns it.
- R6: Host reads at offsets 0 and 3 return 0x00. Subsystem reads at offsets 1 and 3 return 0x00.
- R7: Host writes at offsets 1 and 3 change no state. Subsystem writes at offsets 0 and 3 change no state.
- R8: Read data is registered. It appears on the clock edge that samples the read strobe and holds until the next read strobe on that side. Reads change no latch.
- R9: When one side writes a latch in the same cycle the other side reads it, the read returns the value held before that cycle. The new value is returned only by a read in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 2 | Host offset |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, registered |
| s_wr | input | 1 | Subsystem write strobe |
| s_rd | input | 1 | Subsystem read strobe |
| s_addr | input | 2 | Subsystem offset: 0 incoming data, 1 outgoing data, 2 control |
| s_wdata | input | 8 | Subsystem write data |
| s_rdata | output | 8 | Subsystem read data, registered |

## Verification
A write on one side and a read of the same latch from the other side can land in the same cycle. Examples are a host mailbox write while the subsystem reads its incoming data, and a subsystem control write while the host reads control. Directed steps create both collisions on purpose, and a random phase creates many more. The bench model evaluates every read against the latch values from before the edge and applies writes afterwards. Any write-through shows up as a mismatch on the read-data output in that cycle, or in the cycle after.

// File: rtl/xbr_pkg.sv
package xbr_pkg;
  // Offsets shared by both sides of the bridge.
  localparam int unsigned XBR_OFS_IN   = 0;  // host -> subsystem byte
  localparam int unsigned XBR_OFS_RET  = 1;  // subsystem -> host byte
  localparam int unsigned XBR_OFS_CTL  = 2;  // control nibble exchange
endpackage

// File: rtl/xbr_rst_sync.sv
module xbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_nxt;

  always_comb begin
    sh_nxt = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sh_q <= '0;
    else          sh_q <= sh_nxt;
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/xbr_reg.sv
module xbr_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/xbr_rd_port.sv
module xbr_rd_port
  import xbr_pkg::*;
#(
  parameter int W       = 8,
  parameter int AW      = 2,
  parameter bit IS_HOST = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  mbox,      // mailbox this side reads
  input  logic [W-1:0]  peer_ctl,  // control latch owned by the other side
  output logic [W-1:0]  rdata
);
  localparam int NIB = W / 2;

  logic [W-1:0] ctl_view;
  logic [W-1:0] rd_sel;

  // Peer upper half lands in the lower half of this side's view.
  assign ctl_view = {{(W-NIB){1'b0}}, peer_ctl[W-1:NIB]};

  generate
    if (IS_HOST) begin : g_host
      always_comb begin
        if (addr == AW'(XBR_OFS_RET))      rd_sel = mbox;
        else if (addr == AW'(XBR_OFS_CTL)) rd_sel = ctl_view;
        else                               rd_sel = '0;
      end
    end else begin : g_sub
      always_comb begin
        if (addr == AW'(XBR_OFS_IN))       rd_sel = mbox;
        else if (addr == AW'(XBR_OFS_CTL)) rd_sel = ctl_view;
        else                               rd_sel = '0;
      end
    end
  endgenerate

  xbr_reg #(.W(W)) u_rd_q (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (rd),
    .d    (rd_sel),
    .q    (rdata)
  );
endmodule

// File: rtl/xbr_port_bridge.sv
module xbr_port_bridge
  import xbr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              s_wr,
  input  logic              s_rd,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [DATA_W-1:0] s_wdata,
  output logic [DATA_W-1:0] s_rdata
);
  logic              rst_int_n;
  logic              h2s_we, hctl_we, s2h_we, sctl_we;
  logic [DATA_W-1:0] h2s_q, s2h_q, hctl_q, sctl_q;

  xbr_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n_i(rst_n),
    .rst_n_o(rst_int_n)
  );

  // Write decode: unlisted offsets have no target.
  always_comb begin
    h2s_we  = h_wr && (h_addr == ADDR_W'(XBR_OFS_IN));
    hctl_we = h_wr && (h_addr == ADDR_W'(XBR_OFS_CTL));
    s2h_we  = s_wr && (s_addr == ADDR_W'(XBR_OFS_RET));
    sctl_we = s_wr && (s_addr == ADDR_W'(XBR_OFS_CTL));
  end

  xbr_reg #(.W(DATA_W)) u_h2s  (.clk(clk), .rst_n(rst_int_n), .en(h2s_we),  .d(h_wdata), .q(h2s_q));
  xbr_reg #(.W(DATA_W)) u_hctl (.clk(clk), .rst_n(rst_int_n), .en(hctl_we), .d(h_wdata), .q(hctl_q));
  xbr_reg #(.W(DATA_W)) u_s2h  (.clk(clk), .rst_n(rst_int_n), .en(s2h_we),  .d(s_wdata), .q(s2h_q));
  xbr_reg #(.W(DATA_W)) u_sctl (.clk(clk), .rst_n(rst_int_n), .en(sctl_we), .d(s_wdata), .q(sctl_q));

  xbr_rd_port #(.W(DATA_W), .AW(ADDR_W), .IS_HOST(1'b1)) u_hrd (
    .clk(clk), .rst_n(rst_int_n), .rd(h_rd), .addr(h_addr),
    .mbox(s2h_q), .peer_ctl(sctl_q), .rdata(h_rdata)
  );

  xbr_rd_port #(.W(DATA_W), .AW(ADDR_W), .IS_HOST(1'b0)) u_srd (
    .clk(clk), .rst_n(rst_int_n), .rd(s_rd), .addr(s_addr),
    .mbox(h2s_q), .peer_ctl(hctl_q), .rdata(s_rdata)
  );
endmodule

// File: rtl/xbr_port_bridge_chk.sv
module xbr_port_bridge_chk #(
  parameter int W  = 8,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_wr,
  input logic          h_rd,
  input logic [AW-1:0] h_addr,
  input logic [W-1:0]  h_wdata,
  input logic [W-1:0]  h_rdata,
  input logic          s_wr,
  input logic          s_rd,
  input logic [AW-1:0] s_addr,
  input logic [W-1:0]  s_wdata,
  input logic [W-1:0]  s_rdata,
  input logic [W-1:0]  h2s,
  input logic [W-1:0]  s2h,
  input logic [W-1:0]  hctl,
  input logic [W-1:0]  sctl
);
  localparam int NIB = W / 2;

  a_r1_reset_clear: assert property (@(posedge clk)
    (rst_n && !$past(rst_n)) |->
      (h_rdata == '0 && s_rdata == '0 && h2s == '0 && s2h == '0 && hctl == '0 && sctl == '0));

  a_r2_h2s_load: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == AW'(0)) |=> (h2s == $past(h_wdata)));

  a_r3_hctl_to_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rd && s_addr == AW'(2)) |=> (s_rdata == {{(W-NIB){1'b0}}, $past(hctl[W-1:NIB])}));

  a_r4_sctl_to_host: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && h_addr == AW'(2)) |=> (h_rdata == {{(W-NIB){1'b0}}, $past(sctl[W-1:NIB])}));

  a_r5_s2h_load: assert property (@(posedge clk) disable iff (!rst_n)
    (s_wr && s_addr == AW'(1)) |=> (s2h == $past(s_wdata)));

  a_r6_host_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && (h_addr == AW'(0) || h_addr == AW'(3))) |=> (h_rdata == '0));

  a_r7_host_ofs3_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == AW'(3)) |=> ($stable(hctl) && $stable(h2s)));

  a_r8_host_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !h_rd |=> $stable(h_rdata));

  a_r9_no_write_through: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == AW'(0) && s_rd && s_addr == AW'(0)) |=> (s_rdata == $past(h2s)));
endmodule

bind xbr_port_bridge xbr_port_bridge_chk #(.W(DATA_W), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n),
  .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
  .s_wr(s_wr), .s_rd(s_rd), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
  .h2s(h2s_q), .s2h(s2h_q), .hctl(hctl_q), .sctl(sctl_q)
);

// File: tb/xbr_port_bridge_bench.sv
module xbr_port_bridge_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       h_wr, h_rd, s_wr, s_rd;
  logic [1:0] h_addr, s_addr;
  logic [7:0] h_wdata, s_wdata;
  logic [7:0] h_rdata, s_rdata;

  int n_cmp = 0;
  int n_bad = 0;

  // Behavioural model state
  int m_h2s, m_s2h, m_hctl, m_sctl, m_hrd, m_srd;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbr_port_bridge u_xbr_port_bridge (
    .clk(clk), .rst_n(rst_n),
    .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .s_wr(s_wr), .s_rd(s_rd), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata)
  );

  task automatic idle();
    h_wr = 0; h_rd = 0; s_wr = 0; s_rd = 0;
    h_addr = 0; s_addr = 0; h_wdata = 0; s_wdata = 0;
  endtask

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  // One clock: model reads old state, then applies writes; compare after.
  task automatic cyc(string tag);
    int nh, ns;
    @(posedge clk);
    if (!rst_n) begin
      m_h2s = 0; m_s2h = 0; m_hctl = 0; m_sctl = 0; m_hrd = 0; m_srd = 0;
    end else begin
      nh = m_hrd; ns = m_srd;
      if (h_rd) begin
        if (h_addr == 1)      nh = m_s2h;
        else if (h_addr == 2) nh = m_sctl / 16;
        else                  nh = 0;
      end
      if (s_rd) begin
        if (s_addr == 0)      ns = m_h2s;
        else if (s_addr == 2) ns = m_hctl / 16;
        else                  ns = 0;
      end
      if (h_wr && h_addr == 0) m_h2s  = int'(h_wdata);
      if (h_wr && h_addr == 2) m_hctl = int'(h_wdata);
      if (s_wr && s_addr == 1) m_s2h  = int'(s_wdata);
      if (s_wr && s_addr == 2) m_sctl = int'(s_wdata);
      m_hrd = nh; m_srd = ns;
    end
    @(negedge clk);
    check(tag, "h_rdata", int'(h_rdata), m_hrd);
    check(tag, "s_rdata", int'(s_rdata), m_srd);
    idle();
  endtask

  task automatic do_reset(string tag);
    idle();
    rst_n = 0;
    repeat (3) cyc(tag);
    rst_n = 1;
    repeat (4) cyc(tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    m_h2s = 0; m_s2h = 0; m_hctl = 0; m_sctl = 0; m_hrd = 0; m_srd = 0;
    @(negedge clk);
    do_reset("R1");
    check("R1", "h_rdata after reset", int'(h_rdata), 0);
    check("R1", "s_rdata after reset", int'(s_rdata), 0);

    // R2: host byte reaches subsystem incoming data port
    h_wr = 1; h_addr = 0; h_wdata = 8'hA5; cyc("R2");
    s_rd = 1; s_addr = 0; cyc("R2");
    check("R2", "sub data read", int'(s_rdata), 8'hA5);

    // R3: host control upper nibble -> subsystem low nibble
    h_wr = 1; h_addr = 2; h_wdata = 8'hC3; cyc("R3");
    s_rd = 1; s_addr = 2; cyc("R3");
    check("R3", "sub ctl read", int'(s_rdata), 8'h0C);

    // R4: subsystem control upper nibble -> host low nibble
    s_wr = 1; s_addr = 2; s_wdata = 8'h7E; cyc("R4");
    h_rd = 1; h_addr = 2; cyc("R4");
    check("R4", "host ctl read", int'(h_rdata), 8'h07);

    // R5: subsystem return byte
    s_wr = 1; s_addr = 1; s_wdata = 8'h5A; cyc("R5");
    h_rd = 1; h_addr = 1; cyc("R5");
    check("R5", "host ret read", int'(h_rdata), 8'h5A);

    // R6: unmapped read offsets return zero
    h_rd = 1; h_addr = 0; s_rd = 1; s_addr = 1; cyc("R6");
    check("R6", "host ofs0", int'(h_rdata), 0);
    check("R6", "sub ofs1", int'(s_rdata), 0);
    h_rd = 1; h_addr = 3; s_rd = 1; s_addr = 3; cyc("R6");
    check("R6", "host ofs3", int'(h_rdata), 0);
    check("R6", "sub ofs3", int'(s_rdata), 0);

    // R7: writes to unmapped offsets leave every latch untouched
    h_wr = 1; h_addr = 1; h_wdata = 8'hFF; s_wr = 1; s_addr = 0; s_wdata = 8'hFF; cyc("R7");
    h_wr = 1; h_addr = 3; h_wdata = 8'hFF; s_wr = 1; s_addr = 3; s_wdata = 8'hFF; cyc("R7");
    s_rd = 1; s_addr = 0; h_rd = 1; h_addr = 1; cyc("R7");
    check("R7", "sub data after ignored writes", int'(s_rdata), 8'hA5);
    check("R7", "host ret after ignored writes", int'(h_rdata), 8'h5A);
    s_rd = 1; s_addr = 2; h_rd = 1; h_addr = 2; cyc("R7");
    check("R7", "sub ctl after ignored writes", int'(s_rdata), 8'h0C);
    check("R7", "host ctl after ignored writes", int'(h_rdata), 8'h07);

    // R8: read data holds between strobes; reads have no side effect
    repeat (3) cyc("R8");
    check("R8", "host hold", int'(h_rdata), 8'h07);
    check("R8", "sub hold", int'(s_rdata), 8'h0C);
    h_rd = 1; h_addr = 1; cyc("R8");
    h_rd = 1; h_addr = 1; cyc("R8");
    check("R8", "host repeat read", int'(h_rdata), 8'h5A);

    // R9: same-cycle write and read return the old value
    h_wr = 1; h_addr = 0; h_wdata = 8'h11; s_rd = 1; s_addr = 0; cyc("R9");
    check("R9", "sub data same cycle", int'(s_rdata), 8'hA5);
    s_rd = 1; s_addr = 0; cyc("R9");
    check("R9", "sub data next cycle", int'(s_rdata), 8'h11);
    s_wr = 1; s_addr = 2; s_wdata = 8'h90; h_rd = 1; h_addr = 2; cyc("R9");
    check("R9", "host ctl same cycle", int'(h_rdata), 8'h07);
    h_rd = 1; h_addr = 2; cyc("R9");
    check("R9", "host ctl next cycle", int'(h_rdata), 8'h09);

    // Random traffic with frequent collisions, model compared each clock
    for (int i = 0; i < 600; i++) begin
      h_wr = 1'($urandom); h_rd = 1'($urandom);
      s_wr = 1'($urandom); s_rd = 1'($urandom);
      h_addr = 2'($urandom); s_addr = 2'($urandom);
      h_wdata = 8'($urandom); s_wdata = 8'($urandom);
      cyc("R9");
    end

    // R1 again: reset in mid-run clears everything
    do_reset("R1");
    check("R1", "h_rdata after second reset", int'(h_rdata), 0);
    s_rd = 1; s_addr = 0; h_rd = 1; h_addr = 1; cyc("R1");
    check("R1", "sub data cleared", int'(s_rdata), 0);
    check("R1", "host ret cleared", int'(h_rdata), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule